// File: doc/BRIEF.md
# Programmable Clock Offset and Duty Generator

This block derives two clocks for slow-tester delay-fault testing from a fast tick clock. Each tick stands for one resolution step of a delay line. A phase counter counts the ticks of a programmable reference period. The functional clock is a set-reset pulse: it is set at the start of each period and cleared once its programmed width in ticks has elapsed. The test clock uses the same set-reset scheme with its own width code. Its set point lies a programmed number of ticks after the functional clock's rising edge, so the launch-to-capture gap seen by the logic under test can be stretched.

The period, both width codes, the offset code and the enable are captured only at a period boundary. A code change therefore never cuts a pulse short and never adds an extra edge. When the captured enable is low, the test clock stays high while the functional clock keeps running. A one-tick strobe marks the start of every functional clock cycle.

Top module: `clk_offset_gen`

## Requirements
- R1: While reset is asserted, `fclk` and `cyc_start` are 0 and `tclk` is 1.
- R2: The first period starts on the first clock edge after reset is released. Every period then lasts P ticks, where P is `period_i`, with values 0 and 1 treated as 2.
- R3: In each period, `fclk` is 1 for the first D ticks and 0 for the remaining ticks, where D is the effective functional width code.
- R4: A width code of 0 acts as 1. A width code greater than or equal to P acts as P-1. The same rule applies to both width codes.
- R5: When enabled, `tclk` rises on the tick whose phase equals the effective offset. It stays high for T ticks, where T is the effective test width code, and the pulse may run into the following period. If a new set point arrives while the pulse is still high, the count restarts.
- R6: An offset code greater than or equal to P acts as P-1. An offset code of 0 makes `tclk` rise together with `fclk`.
- R7: While the captured enable is 0, `tclk` is held at 1 and `fclk` is unaffected.
- R8: `period_i`, `fduty_i`, `tduty_i`, `offset_i` and `en_i` are sampled only on the edge that starts a new period. Changes made during a period do not alter that period.
- R9: `cyc_start` is 1 for exactly the first tick of each period, which is the tick on which `fclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one delay step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Test clock enable |
| period_i | input | 8 | Reference period in ticks |
| fduty_i | input | 7 | Functional clock high width code |
| tduty_i | input | 7 | Test clock high width code |
| offset_i | input | 7 | Test clock delay after the functional rising edge |
| fclk | output | 1 | Functional clock |
| tclk | output | 1 | Test clock |
| cyc_start | output | 1 | One-tick strobe at each functional rising edge |

## Verification
The bench drives width codes of 0 and of the period or more. A design without the clamp would drop the functional pulse entirely or hold it high for the whole period, and the `cyc_start` edge would be lost. Offsets at the last phase, combined with long test widths, make the test pulse run past the period boundary. A design that cut the pulse at the boundary would give a short pulse. Codes are also changed in the middle of a period, which catches a design that applies them at once and produces a runt pulse. The bench also toggles the enable, to confirm that `tclk` is forced high and `fclk` keeps its rhythm. Throughout a long random run with period codes of 0 and 1 mixed in, a cycle-by-cycle model is compared against all three outputs.

// File: rtl/clk_offset_gen.sv
`timescale 1ns/1ps
module clk_offset_gen #(
  parameter int PW = 8,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  input  logic [CW-1:0] fduty_i,
  input  logic [CW-1:0] tduty_i,
  input  logic [CW-1:0] offset_i,
  output logic          fclk,
  output logic          tclk,
  output logic          cyc_start
);

  function automatic logic [CW-1:0] fit(input logic [CW-1:0] c, input logic [PW-1:0] p,
                                        input logic zero_ok);
    logic [PW-1:0] ce;
    ce = PW'(c);
    if (!zero_ok && c == '0) return CW'(1);
    if (ce >= p) return CW'(p - PW'(1));
    return c;
  endfunction

  logic          run, sh_en, wrap;
  logic [PW-1:0] phase, sh_p, p_n;
  logic [CW-1:0] sh_fd, sh_td, sh_o, tcnt;

  assign p_n  = (period_i < PW'(2)) ? PW'(2) : period_i;
  assign wrap = !run || (phase == sh_p - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= '0;
      sh_p  <= PW'(2);
      sh_fd <= CW'(1);
      sh_td <= CW'(1);
      sh_o  <= '0;
      sh_en <= 1'b0;
    end else if (wrap) begin
      run   <= 1'b1;
      phase <= '0;
      sh_p  <= p_n;
      sh_fd <= fit(fduty_i, p_n, 1'b0);
      sh_td <= fit(tduty_i, p_n, 1'b0);
      sh_o  <= fit(offset_i, p_n, 1'b1);
      sh_en <= en_i;
    end else begin
      phase <= phase + PW'(1);
    end
  end

  logic tset;
  assign tset = run && (phase == PW'(sh_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tcnt <= '0;
    else if (!sh_en)         tcnt <= '0;
    else if (tset)           tcnt <= sh_td - CW'(1);
    else if (tcnt != '0)     tcnt <= tcnt - CW'(1);
  end

  assign fclk      = run && (phase < PW'(sh_fd));
  assign tclk      = !sh_en || tset || (tcnt != '0);
  assign cyc_start = run && (phase == '0);

  // R9
  cyc_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cyc_start |-> fclk);
  // R9
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fclk) |-> cyc_start);
  // R7
  tclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !sh_en |-> tclk);
  // R8
  hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(sh_p) && $stable(sh_fd) && $stable(sh_td) && $stable(sh_o) && $stable(sh_en)));
  // R4
  last_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == sh_p - PW'(1)) |-> !fclk);
  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n) run |-> phase < sh_p);

endmodule

// File: tb/clk_offset_gen_bench.sv
`timescale 1ns/1ps
module clk_offset_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0;
  logic [7:0] period_i = 8'd10;
  logic [6:0] fduty_i = 7'd3, tduty_i = 7'd3, offset_i = 7'd4;
  logic fclk, tclk, cyc_start;
  int checks = 0, fails = 0;
  bit done = 0;

  clk_offset_gen u_clk_offset_gen (.clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i),
    .fduty_i(fduty_i), .tduty_i(tduty_i), .offset_i(offset_i), .fclk(fclk), .tclk(tclk),
    .cyc_start(cyc_start));

  always #2 clk = ~clk;

  int m_run = 0, m_ph = 0, m_p = 2, m_fd = 1, m_td = 1, m_o = 0, m_en = 0, m_tc = 0;

  function automatic int eff_p(int p); return (p < 2) ? 2 : p; endfunction
  function automatic int eff_w(int c, int p);
    if (c == 0) return 1;
    if (c >= p) return p - 1;
    return c;
  endfunction
  function automatic int eff_o(int c, int p); return (c >= p) ? p - 1 : c; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_model();
    int p;
    if (m_en == 0) m_tc = 0;
    else if (m_run == 1 && m_ph == m_o) m_tc = m_td - 1;
    else if (m_tc != 0) m_tc--;
    if (m_run == 0 || m_ph == m_p - 1) begin
      p = eff_p(int'(period_i));
      m_run = 1; m_ph = 0; m_p = p;
      m_fd = eff_w(int'(fduty_i), p); m_td = eff_w(int'(tduty_i), p);
      m_o = eff_o(int'(offset_i), p); m_en = int'(en_i);
    end else m_ph++;
  endtask

  task automatic tick();
    int ef, et, ec;
    step_model();
    @(negedge clk);
    ef = (m_run == 1 && m_ph < m_fd) ? 1 : 0;
    et = (m_en == 0) ? 1 : (((m_run == 1 && m_ph == m_o) || m_tc != 0) ? 1 : 0);
    ec = (m_run == 1 && m_ph == 0) ? 1 : 0;
    chk("R3 fclk", int'(fclk), ef);
    chk("R5 tclk", int'(tclk), et);
    chk("R9 cyc_start", int'(cyc_start), ec);
  endtask

  task automatic measure(int p, output int fhi, output int trise, output int thi);
    int prev;
    while (cyc_start !== 1'b1) tick();
    fhi = 0; trise = -1; thi = 0; prev = 1;
    for (int i = 0; i < p; i++) begin
      if (fclk) fhi++;
      if (tclk) thi++;
      if (tclk && !prev && trise < 0) trise = i;
      prev = int'(tclk);
      tick();
    end
  endtask

  initial begin
    int fhi, tr, th, cnt;
    repeat (3) @(negedge clk);
    chk("R1 fclk in reset", int'(fclk), 0);
    chk("R1 tclk in reset", int'(tclk), 1);
    chk("R1 cyc_start in reset", int'(cyc_start), 0);
    en_i = 1'b1; period_i = 8'd10; fduty_i = 7'd0; tduty_i = 7'd3; offset_i = 7'd4;
    rst_n = 1'b1;
    tick();
    chk("R2 first period starts", int'(cyc_start), 1);
    repeat (25) tick();
    measure(10, fhi, tr, th);
    chk("R4 zero width acts as one", fhi, 1);
    chk("R5 tclk rise at offset", tr, 4);
    chk("R5 tclk width", th, 3);
    fduty_i = 7'd127; offset_i = 7'd127;
    repeat (25) tick();
    measure(10, fhi, tr, th);
    chk("R4 oversize width clamped", fhi, 9);
    chk("R6 oversize offset clamped", tr, 9);
    en_i = 1'b0;
    repeat (25) tick();
    measure(10, fhi, tr, th);
    chk("R7 tclk held high", th, 10);
    chk("R7 fclk unaffected", fhi, 9);
    en_i = 1'b1; fduty_i = 7'd3; period_i = 8'd12;
    repeat (30) tick();
    while (cyc_start !== 1'b1) tick();
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      if (fclk) cnt++;
      if (i == 1) begin fduty_i = 7'd8; period_i = 8'd6; end
      tick();
    end
    chk("R8 mid-period change deferred", cnt, 3);
    chk("R2 new period applies next", int'(cyc_start), 1);
    void'($urandom(32'd1234));
    for (int n = 0; n < 20000; n++) begin
      if ($urandom_range(0, 30) == 0)
        period_i = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 40));
      if ($urandom_range(0, 25) == 0) fduty_i = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 25) == 0) tduty_i = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 25) == 0) offset_i = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 60) == 0) en_i = ~en_i;
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule